// File: doc/BRIEF.md
# Three-Channel Voltage DAC Code Register Interface

This block is the digital front end of a three-channel, 8-bit voltage DAC. The channels share one parallel data bus. A 2-bit address and an active-low write strobe steer that bus into one of three channel code registers. A fourth address value does not select a register. Writing to it puts the converter into a low-power shutdown state. A later write to any channel address ends shutdown, stores that write's data and keeps every other stored code.

The strobe, address and data come from a slower external bus. Each is passed through a two-stage synchronizer into the system clock domain. A write acts as a level-sensitive update: while the synchronized strobe is low, the addressed register follows the data bus. The value present at the last low sample is the one that stays.

The block drives the held codes and a per-channel output-enable flag, which is low during shutdown. It also drives an output-valid flag. That flag stays low for a parameterised recovery time, counted in clock cycles, after shutdown ends. For debug, each channel's ideal output level is given as code × reference / 256.

Top module: `tri_dac_regif`

## Requirements
- R1: After reset, all three codes are 0x00, shutdown is low, all output enables are high and output-valid is high.
- R2: Address 0, 1 and 2 select channel A, B and C. Channel i's code sits at `ch_codes[8*i +: 8]`.
- R3: While the synchronized strobe is low, the addressed code follows the data bus. Once the strobe is high, the code holds the data of the last low sample.
- R4: A write to address 3 sets shutdown and changes no channel code.
- R5: A write to address 0, 1 or 2 during shutdown clears shutdown and stores its data in that channel only. The other codes keep their values.
- R6: A write to address 3 during shutdown changes neither the codes nor the power state.
- R7: Every bit of `out_en` is low exactly while shutdown is set.
- R8: Output-valid is low during shutdown. After the clock edge that clears shutdown, it rises exactly RECOV_CYC cycles later, where RECOV_CYC = CLK_MHZ × RECOV_NS / 1000 (1625 by default).
- R9: Entering shutdown again during recovery cancels the count. The next exit waits a full RECOV_CYC cycles.
- R10: `dbg_levels[16*i +: 16]` equals floor(code_i × REF_MV / 256).
- R11: An input change applied just after a clock edge first shows on the code outputs after the third following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on preset) |
| wr_n | input | 1 | Active-low write strobe, asynchronous to clk |
| addr | input | 2 | Channel select; value 3 requests shutdown |
| data | input | 8 | Shared code data bus |
| ch_codes | output | 24 | Held codes, channel i at bits [8i+7:8i] |
| shdn | output | 1 | Low-power shutdown state |
| out_en | output | 3 | Per-channel output drive enable, low in shutdown |
| out_valid | output | 1 | Outputs settled; low in shutdown and during recovery |
| dbg_levels | output | 48 | Ideal level per channel, code × REF_MV / 256 |

## Verification
The assertions assume that address and data are stable for at least three clock cycles around each strobe edge. This keeps the synchronized copies aligned with one another. They also assume that the strobe never touches two channels within a single cycle. The bench drives every input on the falling clock edge. It changes address only while the strobe is high, and it changes data during a low phase only to exercise the level-following behaviour. All three inputs therefore pass through the synchronizers together.

// File: rtl/tdac_pkg.sv
package tdac_pkg;
  parameter int CODE_W = 8;
  parameter int ADDR_W = 2;
  parameter int N_CH   = 3;
  localparam logic [ADDR_W-1:0] SHDN_ADDR = '1;

  typedef struct packed {
    logic              strobe_n;
    logic [ADDR_W-1:0] sel;
    logic [CODE_W-1:0] bus;
  } tdac_req_t;

  localparam int REQ_W = $bits(tdac_req_t);
endpackage

// File: rtl/tdac_sync.sv
module tdac_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tdac_code_bank.sv
module tdac_code_bank
  import tdac_pkg::*;
#(
  parameter int REF_W  = 16,
  parameter int REF_MV = 3300
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_lo,
  input  logic [ADDR_W-1:0]       sel,
  input  logic [CODE_W-1:0]       bus,
  output logic [N_CH*CODE_W-1:0]  codes,
  output logic [N_CH*REF_W-1:0]   levels
);
  localparam int PROD_W = CODE_W + REF_W;
  localparam logic [PROD_W-1:0] REF_EXT = PROD_W'(REF_MV);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    logic [PROD_W-1:0] prod;
    logic              hit;

    assign hit = wr_lo && (sel == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst)      code_q <= '0;
      else if (hit) code_q <= bus;
    end

    assign prod = {{REF_W{1'b0}}, code_q} * REF_EXT;
    assign codes[i*CODE_W +: CODE_W] = code_q;
    assign levels[i*REF_W +: REF_W]  = prod[CODE_W +: REF_W];
  end
endmodule

// File: rtl/tdac_power.sv
module tdac_power
  import tdac_pkg::*;
#(
  parameter int RECOV_CYC = 1625
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_lo,
  input  logic sel_shdn,
  output logic shdn,
  output logic valid
);
  localparam int CNT_W = $clog2(RECOV_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RECOV_CYC);

  logic [CNT_W-1:0] remain;
  logic             enter, leave;

  assign enter = wr_lo && sel_shdn;
  assign leave = wr_lo && !sel_shdn && shdn;

  always_ff @(posedge clk) begin
    if (rst) begin
      shdn   <= 1'b0;
      remain <= '0;
      valid  <= 1'b1;
    end else if (enter) begin
      shdn   <= 1'b1;
      remain <= '0;
      valid  <= 1'b0;
    end else if (leave) begin
      shdn   <= 1'b0;
      remain <= LOAD;
      valid  <= 1'b0;
    end else if (!shdn && remain != '0) begin
      remain <= remain - 1'b1;
      valid  <= (remain == CNT_W'(1));
    end
  end
endmodule

// File: rtl/tri_dac_regif.sv
module tri_dac_regif
  import tdac_pkg::*;
#(
  parameter int CLK_MHZ  = 125,
  parameter int RECOV_NS = 13000,
  parameter int REF_W    = 16,
  parameter int REF_MV   = 3300
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [CODE_W-1:0]      data,
  output logic [N_CH*CODE_W-1:0] ch_codes,
  output logic                   shdn,
  output logic [N_CH-1:0]        out_en,
  output logic                   out_valid,
  output logic [N_CH*REF_W-1:0]  dbg_levels
);
  localparam int RECOV_CYC = (CLK_MHZ * RECOV_NS) / 1000;
  localparam logic [REQ_W-1:0] IDLE_REQ = {1'b1, {(REQ_W-1){1'b0}}};

  tdac_req_t raw_req, s_req;
  logic      wr_lo;

  assign raw_req = '{strobe_n: wr_n, sel: addr, bus: data};

  tdac_sync #(.W(REQ_W), .STAGES(2), .RST_VAL(IDLE_REQ)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_req),
    .q   (s_req)
  );

  assign wr_lo = !s_req.strobe_n;

  tdac_code_bank #(.REF_W(REF_W), .REF_MV(REF_MV)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_lo  (wr_lo),
    .sel    (s_req.sel),
    .bus    (s_req.bus),
    .codes  (ch_codes),
    .levels (dbg_levels)
  );

  tdac_power #(.RECOV_CYC(RECOV_CYC)) u_pwr (
    .clk      (clk),
    .rst      (rst),
    .wr_lo    (wr_lo),
    .sel_shdn (s_req.sel == SHDN_ADDR),
    .shdn     (shdn),
    .valid    (out_valid)
  );

  assign out_en = {N_CH{~shdn}};
endmodule

// File: rtl/tdac_chk.sv
module tdac_chk
  import tdac_pkg::*;
#(
  parameter int RECOV_CYC = 1625
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_CH*CODE_W-1:0] ch_codes,
  input logic                   shdn,
  input logic                   out_valid
);
  localparam int CW = $clog2(RECOV_CYC + 1);

  logic [CW-1:0]           since_exit;
  logic [N_CH*CODE_W-1:0]  prev_codes;
  logic [N_CH-1:0]         moved;

  always_ff @(posedge clk) begin
    if (rst)                         since_exit <= CW'(RECOV_CYC);
    else if (shdn)                   since_exit <= '0;
    else if (since_exit < CW'(RECOV_CYC)) since_exit <= since_exit + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) prev_codes <= '0;
    else     prev_codes <= ch_codes;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_mv
    assign moved[i] = ch_codes[i*CODE_W +: CODE_W] != prev_codes[i*CODE_W +: CODE_W];
  end

  // R8
  a_r8_invalid_in_shdn: assert property (@(posedge clk) disable iff (rst)
    shdn |-> !out_valid);
  // R8
  a_r8_low_at_exit: assert property (@(posedge clk) disable iff (rst)
    $fell(shdn) |-> !out_valid);
  // R8, R9: a full recovery window since the last shutdown
  a_r8_full_window: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> since_exit >= CW'(RECOV_CYC));
  // R4
  a_r4_entry_keeps_codes: assert property (@(posedge clk) disable iff (rst)
    $rose(shdn) |-> $stable(ch_codes));
  // R6
  a_r6_codes_frozen_in_shdn: assert property (@(posedge clk) disable iff (rst)
    (shdn && $past(shdn)) |-> $stable(ch_codes));
  // R2: one channel at most per cycle
  a_r2_single_channel: assert property (@(posedge clk) disable iff (rst)
    $countones(moved) <= 1);
endmodule

bind tri_dac_regif tdac_chk #(.RECOV_CYC(RECOV_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ch_codes  (ch_codes),
  .shdn      (shdn),
  .out_valid (out_valid)
);

// File: tb/tri_dac_regif_tb.sv
module tri_dac_regif_tb;
  localparam int RECOV = 1625;
  localparam int REFMV = 3300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  data = '0;
  logic [23:0] ch_codes;
  logic        shdn;
  logic [2:0]  out_en;
  logic        out_valid;
  logic [47:0] dbg_levels;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tri_dac_regif u_dut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .addr(addr), .data(data),
    .ch_codes(ch_codes), .shdn(shdn), .out_en(out_en),
    .out_valid(out_valid), .dbg_levels(dbg_levels)
  );

  // Behavioural reference model
  int        m_code [3];
  bit        m_sd;
  bit        m_val;
  int        m_left;
  logic [10:0] pipe [$];

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_code[i]) m_code[i] = 0;
      m_sd = 0; m_val = 1; m_left = 0;
      pipe.delete();
      pipe.push_back(11'h400);
      pipe.push_back(11'h400);
    end else begin
      logic [10:0] s;
      s = pipe.pop_front();
      pipe.push_back({wr_n, addr, data});
      if (!s[10]) begin
        int a;
        a = int'(s[9:8]);
        if (a == 3) begin
          m_sd = 1; m_left = 0; m_val = 0;
        end else begin
          m_code[a] = int'(s[7:0]);
          if (m_sd) begin
            m_sd = 0; m_left = RECOV; m_val = 0;
          end else if (m_left > 0) begin
            m_left--; if (m_left == 0) m_val = 1;
          end
        end
      end else if (!m_sd && m_left > 0) begin
        m_left--; if (m_left == 0) m_val = 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int i = 0; i < 3; i++) begin
        chk("R2 code", int'(ch_codes[8*i +: 8]), m_code[i]);
        chk("R10 level", int'(dbg_levels[16*i +: 16]), (m_code[i] * REFMV) / 256);
      end
      chk("R4 shutdown", int'(shdn), int'(m_sd));
      chk("R7 out_en", int'(out_en), m_sd ? 0 : 7);
      chk("R8 valid", int'(out_valid), int'(m_val));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, int low);
    @(negedge clk); addr = a; data = d;
    idle(3);
    wr_n = 1'b0;
    idle(low);
    wr_n = 1'b1;
    idle(5);
  endtask

  function automatic int code_of(int i);
    return int'(ch_codes[8*i +: 8]);
  endfunction

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    chk("R1 codes", int'(ch_codes), 0);
    chk("R1 shdn", int'(shdn), 0);
    chk("R1 en", int'(out_en), 7);
    chk("R1 valid", int'(out_valid), 1);

    wr(2'd0, 8'h11, 2);
    wr(2'd1, 8'h22, 1);
    wr(2'd2, 8'hF0, 3);
    chk("R2 chA", code_of(0), 8'h11);
    chk("R2 chB", code_of(1), 8'h22);
    chk("R2 chC", code_of(2), 8'hF0);

    // R11 latency
    @(negedge clk); addr = 2'd1; data = 8'h5A; wr_n = 1'b0;
    idle(2);
    chk("R11 before", code_of(1), 8'h22);
    idle(1);
    chk("R11 after", code_of(1), 8'h5A);
    wr_n = 1'b1; idle(5);

    // R3 level following, final value at last low sample
    @(negedge clk); addr = 2'd0; data = 8'h01; idle(3);
    wr_n = 1'b0; idle(4);
    data = 8'h80; idle(4);
    chk("R3 follows", code_of(0), 8'h80);
    data = 8'hFF; idle(1);
    wr_n = 1'b1; idle(6);
    chk("R3 final", code_of(0), 8'hFF);
    data = 8'h33; idle(6);
    chk("R3 hold", code_of(0), 8'hFF);

    // R4 shutdown entry
    wr(2'd3, 8'h99, 2);
    chk("R4 shdn", int'(shdn), 1);
    chk("R4 keep", int'(ch_codes), {8'hF0, 8'h5A, 8'hFF});
    chk("R7 en off", int'(out_en), 0);
    // R6 repeated shutdown write
    wr(2'd3, 8'h44, 3);
    chk("R6 shdn", int'(shdn), 1);
    chk("R6 keep", int'(ch_codes), {8'hF0, 8'h5A, 8'hFF});

    // R5 exit via channel B
    wr(2'd1, 8'h07, 1);
    chk("R5 shdn", int'(shdn), 0);
    chk("R5 codes", int'(ch_codes), {8'hF0, 8'h07, 8'hFF});
    chk("R8 recovering", int'(out_valid), 0);

    // R9 cancel mid-recovery then full wait
    idle(200);
    wr(2'd3, 8'h00, 1);
    chk("R9 shdn again", int'(shdn), 1);
    wr(2'd2, 8'hC3, 1);
    idle(RECOV - 20);
    chk("R9 still low", int'(out_valid), 0);
    idle(40);
    chk("R8 valid", int'(out_valid), 1);
    chk("R10 chC", int'(dbg_levels[32 +: 16]), (8'hC3 * REFMV) / 256);

    // normal write does not disturb valid
    wr(2'd0, 8'h00, 2);
    chk("R8 stays", int'(out_valid), 1);
    idle(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule